// File: doc/BRIEF.md
# Parallel Configuration Readback Engine

This block pulls a requested number of bytes back out of a target device through its byte-wide slave configuration port. It owns the target's select line and its configuration clock, reads the 8-bit data bus once per clock pulse, and passes each byte downstream on a valid/ready stream. The command sequence that puts the target into readback is issued elsewhere, before this block is started. The bytes are not checked here; any integrity check belongs to a later stage.

A one-cycle start pulse together with a byte count begins an operation. The first step asserts the select line while the configuration clock stays high. The block then issues one low-then-high clock pulse per byte and captures the bus at the end of each high phase. When the downstream side stalls, the block holds the configuration clock high, so no byte is overwritten. After the last byte has been accepted, the block releases the select line and gives one extra full clock pulse. It then raises a one-cycle done flag. Each clock phase lasts a parameterised number of system clocks.

Top module: `cfg_readback`

## Requirements
- R1: While reset is applied and once it is released, the select output is low (released), the configuration clock output is high, the stream valid output is low and done is low.
- R2: A start pulse with a non-zero count raises the select output while the configuration clock stays high for exactly HALF_CYC system clocks before the first low phase.
- R3: For a count of N, the configuration clock goes low exactly N times while select is high. Each low phase lasts HALF_CYC system clocks and is followed by a high phase of HALF_CYC system clocks.
- R4: Byte k, counted from 1, is the value the data bus holds in the last system clock of the k-th high phase. Bytes leave on the stream in order, unmodified. While valid is high and ready is low, valid stays high and the data stays stable.
- R5: While valid is high and ready is low, the configuration clock stays high, so no byte is lost.
- R6: Once the last byte has been accepted, select falls and exactly one further low-then-high pulse follows with select low, its low phase lasting HALF_CYC system clocks.
- R7: done is high for exactly one system clock at the end of each operation.
- R8: A start pulse with a count of zero raises done at the first system clock edge after the start. It produces no clock pulses and never raises select.
- R9: A start pulse that arrives while an operation is in progress is ignored, and the operation in progress still delivers its original count of bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin a readback |
| byte_count_i | input | CNT_W | Number of bytes to read, sampled with start_i |
| out_ready_i | input | 1 | Downstream ready |
| cfg_data_i | input | DATA_W | Target data bus |
| cfg_sel_o | output | 1 | Target select, high = asserted |
| cfg_clk_o | output | 1 | Target configuration clock |
| out_valid_o | output | 1 | Stream byte valid |
| out_data_o | output | DATA_W | Stream byte |
| done_o | output | 1 | One-cycle end-of-operation flag |

## Verification
The bench builds the block with HALF_CYC = 2 and CNT_W = 4. At these values every legal byte count from 0 to 15 can be swept against three downstream ready patterns: always ready, ready one cycle in three, and long stalls. A behavioural target advances its bus value on every falling configuration clock, so each expected byte is a simple formula of its index. The phase lengths, pulse counts and stall behaviour are counted cycle by cycle from the outputs. Each non-empty run also receives a second start pulse while it is busy.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_HOLD  = 3'd4,
    ST_TLOW  = 3'd5,
    ST_THIGH = 3'd6,
    ST_FIN   = 3'd7
  } rb_state_e;
endpackage

// File: rtl/rb_rst_sync.sv
module rb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rb_phase_timer.sv
module rb_phase_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic last_o
);
  localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  assign last_o = en_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) cnt_d = last_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // phase counter never leaves its half-period window
  assert_timer_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rb_byte_counter.sv
module rb_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             is_one_o
);
  logic [CNT_W-1:0] left_q, left_d;

  assign is_one_o = (left_q == CNT_W'(1));

  always_comb begin
    left_d = left_q;
    if (load_i)     left_d = load_val_i;
    else if (dec_i) left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (left_q != '0));
endmodule

// File: rtl/rb_out_stage.sv
module rb_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;

  assign data_en = capture_i;

  always_comb begin
    valid_d = valid_q;
    if (capture_i)            valid_d = 1'b1;
    else if (valid_q && ready_i) valid_d = 1'b0;
    data_d = bus_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // a held byte is never overwritten by a fresh capture
  assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |-> !valid_q);
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
  import rb_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  input  logic              out_ready_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output logic              cfg_sel_o,
  output logic              cfg_clk_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              done_o
);
  logic      rst_n_s;
  rb_state_e state_q, state_d;
  logic      tmr_en, tmr_last;
  logic      cnt_load, cnt_dec, cnt_is_one;
  logic      capture;
  logic      sel_q, sel_d, cclk_q, cclk_d, done_q, done_d;

  rb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  rb_phase_timer #(.HALF_CYC(HALF_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .en_i(tmr_en), .last_o(tmr_last)
  );

  rb_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .load_i(cnt_load), .load_val_i(byte_count_i),
    .dec_i(cnt_dec), .is_one_o(cnt_is_one)
  );

  rb_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n_s), .capture_i(capture), .bus_i(cfg_data_i),
    .ready_i(out_ready_i), .valid_o(out_valid_o), .data_o(out_data_o)
  );

  assign tmr_en = (state_q == ST_SETUP) || (state_q == ST_LOW) ||
                  (state_q == ST_HIGH)  || (state_q == ST_TLOW) ||
                  (state_q == ST_THIGH);

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cnt_load = 1'b1;
          state_d  = (byte_count_i == '0) ? ST_FIN : ST_SETUP;
        end
      end
      ST_SETUP: if (tmr_last) state_d = ST_LOW;
      ST_LOW:   if (tmr_last) state_d = ST_HIGH;
      ST_HIGH: begin
        if (tmr_last) begin
          capture = 1'b1;
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (out_ready_i) begin
          cnt_dec = 1'b1;
          state_d = cnt_is_one ? ST_TLOW : ST_LOW;
        end
      end
      ST_TLOW:  if (tmr_last) state_d = ST_THIGH;
      ST_THIGH: if (tmr_last) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    sel_d  = (state_d == ST_SETUP) || (state_d == ST_LOW) ||
             (state_d == ST_HIGH)  || (state_d == ST_HOLD);
    cclk_d = !((state_d == ST_LOW) || (state_d == ST_TLOW));
    done_d = (state_d == ST_FIN);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      cclk_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      cclk_q  <= cclk_d;
      done_q  <= done_d;
    end
  end

  assign cfg_sel_o = sel_q;
  assign cfg_clk_o = cclk_q;
  assign done_o    = done_q;

  assert_hold_clk_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid_o && !out_ready_i) |=> cfg_clk_o);

  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> !done_o);

  assert_tail_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(cfg_sel_o) |-> (!cfg_clk_o && $past(cfg_clk_o)));

  assert_idle_clk_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> (cfg_clk_o && !cfg_sel_o && !out_valid_o));
endmodule

// File: tb/tb_cfg_readback.sv
`timescale 1ns/1ps
module tb_cfg_readback;
  localparam int HALF = 2;
  localparam int CW   = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [CW-1:0] bcount;
  logic          ready;
  logic [7:0]    bus;
  logic          sel, cclk, valid, done;
  logic [7:0]    odata;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cfg_readback #(.HALF_CYC(HALF), .CNT_W(CW), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .byte_count_i(bcount),
    .out_ready_i(ready), .cfg_data_i(bus), .cfg_sel_o(sel), .cfg_clk_o(cclk),
    .out_valid_o(valid), .out_data_o(odata), .done_o(done)
  );

  // monitor state
  int   mode, seed, cyc, rtick;
  int   fcount, falls_on, falls_off, low_on, low_off, setup_hi, sel_cycles;
  int   done_cnt, done_tick, hold_viol, stab_viol, nbytes;
  logic prev_cclk, prev_valid, prev_ready;
  logic [7:0] prev_data;
  logic [7:0] got [0:31];

  function automatic logic [7:0] fpat(int k, int s);
    return 8'((k * 37 + s) & 8'hFF);
  endfunction

  function automatic logic ready_pat(int m, int c);
    if (m == 0) return 1'b1;
    if (m == 1) return (c % 3) == 0;
    return (c % 8) >= 6;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    logic nr;
    @(negedge clk);
    cyc++;
    rtick++;
    if (sel) sel_cycles++;
    if (prev_cclk && !cclk) begin
      if (sel) begin
        falls_on++;
        fcount++;
        bus = fpat(fcount, seed);
      end else falls_off++;
    end
    if (!cclk && sel)  low_on++;
    if (!cclk && !sel && rst_n) low_off++;
    if (sel && cclk && fcount == 0) setup_hi++;
    if (done) begin
      if (done_cnt == 0) done_tick = rtick;
      done_cnt++;
    end
    if (prev_valid && !prev_ready) begin
      if (!cclk) hold_viol++;
      if (!valid || odata != prev_data) stab_viol++;
    end
    nr = ready_pat(mode, cyc);
    ready = nr;
    if (valid && nr && nbytes < 32) begin
      got[nbytes] = odata;
      nbytes++;
    end
    prev_cclk  = cclk;
    prev_valid = valid;
    prev_ready = nr;
    prev_data  = odata;
  endtask

  task automatic run_case(input int n, input int m, input int id);
    int guard;
    mode = m; seed = id * 11; fcount = 0; bus = fpat(0, seed);
    falls_on = 0; falls_off = 0; low_on = 0; low_off = 0; setup_hi = 0;
    sel_cycles = 0; done_cnt = 0; done_tick = -1; hold_viol = 0;
    stab_viol = 0; nbytes = 0; rtick = 0;
    start = 1'b1; bcount = CW'(n);
    tick();
    start = 1'b0;
    if (n > 0) begin
      tick(); tick();
      start = 1'b1; bcount = CW'(1);   // R9: must be ignored while busy
      tick();
      start = 1'b0;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 3000) begin tick(); guard++; end
    repeat (4) tick();
    check(done_cnt == 1, "R7 done pulse width", done_cnt, 1);
    if (n == 0) begin
      check(done_tick == 1, "R8 zero-count done latency", done_tick, 1);
      check(falls_on + falls_off == 0, "R8 no clock pulses", falls_on + falls_off, 0);
      check(sel_cycles == 0, "R8 select never raised", sel_cycles, 0);
    end else begin
      check(nbytes == n, "R9 byte count despite busy start", nbytes, n);
      check(setup_hi == HALF, "R2 setup with clock high", setup_hi, HALF);
      check(falls_on == n, "R3 low pulses with select", falls_on, n);
      check(low_on == n * HALF, "R3 low phase length", low_on, n * HALF);
      check(falls_off == 1, "R6 tail pulse count", falls_off, 1);
      check(low_off == HALF, "R6 tail low length", low_off, HALF);
      check(hold_viol == 0, "R5 clock held high on stall", hold_viol, 0);
      check(stab_viol == 0, "R4 stream stable on stall", stab_viol, 0);
      for (int k = 0; k < n && k < nbytes; k++)
        check(got[k] == fpat(k + 1, seed), "R4 byte value", got[k], fpat(k + 1, seed));
      check(!sel && cclk && !valid, "R1 idle after operation", {sel, cclk, valid}, 3'b010);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    int id;
    rst_n = 1'b0; start = 1'b0; bcount = '0; ready = 1'b0; bus = 8'h00;
    mode = 0; seed = 0; cyc = 0; rtick = 0; fcount = 0;
    prev_cclk = 1'b1; prev_valid = 1'b0; prev_ready = 1'b0; prev_data = 8'h00;
    falls_on = 0; falls_off = 0; low_on = 0; low_off = 0; setup_hi = 0;
    sel_cycles = 0; done_cnt = 0; done_tick = -1; hold_viol = 0;
    stab_viol = 0; nbytes = 0;
    repeat (3) tick();
    check(!sel && cclk && !valid && !done, "R1 reset state",
          {sel, cclk, valid, done}, 4'b0100);
    rst_n = 1'b1;
    repeat (4) tick();
    check(!sel && cclk && !valid && !done, "R1 after reset release",
          {sel, cclk, valid, done}, 4'b0100);
    id = 1;
    for (int m = 0; m < 3; m++) begin
      for (int n = 0; n < (1 << CW); n++) begin
        run_case(n, m, id);
        id++;
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule